// File: doc/BRIEF.md
# Frame Slip Lock Controller

This block brings the field sequence of an internal video timing chain into step with an external one. It does this without forcing a hard restart in the slow modes. It watches two one-cycle strobes: the start of an internal frame from the local line counter, and a vertical strobe taken from external sync. It measures how many lines separate them. It then asks the line counter, once per frame, either to insert one extra line or to drop one line. The sign of the error decides which. Repeated frames close the gap a line at a time.

A two-bit mode input selects how locking works:
- `00`: the generator follows its subcarrier, and the frame logic is idle.
- `01`: slow lock, with an external line reference.
- `10`: slow lock, with an internal line reference.
- `11`: fast lock. Each external vertical strobe becomes an immediate counter reset request.

A vertical-lock enable gates every correction. A qualifier raises a lock flag once the two strobes have agreed for a set number of frames in a row.

Top module: `frame_slip_lock`

## Requirements
- R1: With `lock_mode` = `00`, no line insert, line drop or frame reset request is made. On the cycle after any cycle in which `lock_mode` is `00`, `in_lock` is low.
- R2: In a slow mode (`lock_mode` `01` or `10`) with `vlock_en` high, suppose `ext_vert` comes first and `int_frame` follows one or more `line_tick` pulses later, within the window. Then `line_drop` is high for exactly one cycle, the cycle after the `int_frame` strobe.
- R3: In a slow mode with `vlock_en` high, suppose `int_frame` comes first and `ext_vert` follows one or more `line_tick` pulses later, within the window. Then `line_add` is high for exactly one cycle, the cycle after the `ext_vert` strobe.
- R4: When both strobes occur with no `line_tick` between them, including the same cycle, no `line_add` or `line_drop` is produced.
- R5: `line_add` and `line_drop` are never high together. Each measured frame produces at most one request.
- R6: With `vlock_en` low, `line_add`, `line_drop` and `frame_reset` stay low in every mode.
- R7: With `lock_mode` = `11` and `vlock_en` high, each `ext_vert` strobe gives a one-cycle `frame_reset` on the next cycle. `line_add` and `line_drop` stay low in that mode.
- R8: The window is half a frame (`LINES_PER_FRAME/2` line ticks) after the first strobe. If the other strobe has not come when it closes, no request is made and `in_lock` goes low.
- R9: A measurement whose separation is at most one `line_tick` counts as a good frame. `in_lock` rises on the cycle after the `LOCK_FRAMES`-th good frame in a row. It falls on the cycle after any measurement separated by more than one tick, or after a window that closes with no second strobe.
- R10: While reset is held and on the first cycle after release, all four outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_mode | input | 2 | 00 subcarrier, 01 slow/external line ref, 10 slow/internal line ref, 11 fast |
| vlock_en | input | 1 | Vertical lock enable; low blocks all corrections |
| line_tick | input | 1 | One-cycle pulse per line period |
| int_frame | input | 1 | One-cycle internal frame-start strobe |
| ext_vert | input | 1 | One-cycle external vertical strobe |
| line_add | output | 1 | Request to insert one line this frame |
| line_drop | output | 1 | Request to remove one line this frame |
| frame_reset | output | 1 | Fast-mode request to restart the internal counters |
| in_lock | output | 1 | Frame lock qualified |

## Verification
The assertions assume that each strobe is a single-cycle pulse. They also assume that a second strobe of the same kind does not arrive before the window opened by the first one has closed. Under those assumptions a completed measurement always has at least one idle cycle behind it, so the requests stay one-cycle pulses. The stimulus drives every strobe through one task that clears it on the next cycle. It spaces frame pairs well beyond the window, and it changes mode only while no measurement is open, with mode `00` used to clear the state between scenarios.

// File: rtl/fsl_pkg.sv
package fsl_pkg;

  typedef enum logic [1:0] {
    MODE_SUBCARRIER = 2'b00,
    MODE_SLOW_EXTREF = 2'b01,
    MODE_SLOW_INTREF = 2'b10,
    MODE_FAST        = 2'b11
  } lock_mode_e;

  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_WAIT_EXT = 2'd1,
    MS_WAIT_INT = 2'd2
  } meas_state_e;

  // Result of one phase measurement, valid for a single cycle.
  typedef struct packed {
    logic done;     // second strobe seen inside the window
    logic ext_led;  // external strobe came first
    logic expired;  // window closed without second strobe
  } meas_evt_t;

endpackage

// File: rtl/fsl_phase_meter.sv
module fsl_phase_meter
  import fsl_pkg::*;
#(
  parameter int HALF_LINES = 312,
  parameter int CNT_W      = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             line_tick,
  input  logic             int_frame,
  input  logic             ext_vert,
  output meas_evt_t        evt,
  output logic [CNT_W-1:0] err
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HALF_LINES - 1);

  meas_state_e      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    evt   = '0;
    err   = (st_q == MS_IDLE) ? '0 : cnt_q;
    if (!active) begin
      st_d  = MS_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        MS_IDLE: begin
          cnt_d = '0;
          if (int_frame && ext_vert) begin
            evt.done = 1'b1;
          end else if (int_frame) begin
            st_d = MS_WAIT_EXT;
          end else if (ext_vert) begin
            st_d = MS_WAIT_INT;
          end
        end
        MS_WAIT_EXT: begin
          if (ext_vert) begin
            evt.done = 1'b1;
            st_d     = MS_IDLE;
          end else if (line_tick) begin
            if (cnt_q == LAST_CNT) begin
              evt.expired = 1'b1;
              st_d        = MS_IDLE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        MS_WAIT_INT: begin
          if (int_frame) begin
            evt.done    = 1'b1;
            evt.ext_led = 1'b1;
            st_d        = MS_IDLE;
          end else if (line_tick) begin
            if (cnt_q == LAST_CNT) begin
              evt.expired = 1'b1;
              st_d        = MS_IDLE;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        default: st_d = MS_IDLE;
      endcase
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= MS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fsl_lock_qual.sv
module fsl_lock_qual #(
  parameter int LOCK_FRAMES = 2,
  parameter int ERR_W       = 9,
  parameter int TOL_LINES   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             meas_done,
  input  logic             meas_expired,
  input  logic [ERR_W-1:0] err,
  output logic             in_lock
);

  localparam int               GOOD_W   = $clog2(LOCK_FRAMES + 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX = GOOD_W'(LOCK_FRAMES);
  localparam logic [ERR_W-1:0]  TOL_V    = ERR_W'(TOL_LINES);

  logic [GOOD_W-1:0] good_q, good_d;
  logic              lock_q, lock_d;
  logic              upd_en;

  always_comb begin
    good_d = good_q;
    lock_d = lock_q;
    if (!active || meas_expired || (meas_done && (err > TOL_V))) begin
      good_d = '0;
      lock_d = 1'b0;
    end else if (meas_done) begin
      good_d = (good_q == GOOD_MAX) ? good_q : good_q + 1'b1;
      lock_d = (good_d == GOOD_MAX);
    end
  end

  assign upd_en = !active || meas_done || meas_expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      good_q <= '0;
      lock_q <= 1'b0;
    end else if (upd_en) begin
      good_q <= good_d;
      lock_q <= lock_d;
    end
  end

  assign in_lock = lock_q;

endmodule

// File: rtl/fsl_corr_req.sv
module fsl_corr_req
  import fsl_pkg::*;
#(
  parameter int ERR_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       lock_mode,
  input  logic             vlock_en,
  input  logic             ext_vert,
  input  meas_evt_t        evt,
  input  logic [ERR_W-1:0] err,
  output logic             line_add,
  output logic             line_drop,
  output logic             frame_reset
);

  logic slow_mode, fast_mode, need_fix;
  logic add_d, drop_d, rst_d;
  logic add_q, drop_q, rst_q;

  always_comb begin
    slow_mode = (lock_mode == MODE_SLOW_EXTREF) || (lock_mode == MODE_SLOW_INTREF);
    fast_mode = (lock_mode == MODE_FAST);
    need_fix  = vlock_en && slow_mode && evt.done && (err != '0);
    add_d     = need_fix && !evt.ext_led;
    drop_d    = need_fix && evt.ext_led;
    rst_d     = vlock_en && fast_mode && ext_vert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_q  <= 1'b0;
      drop_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      add_q  <= add_d;
      drop_q <= drop_d;
      rst_q  <= rst_d;
    end
  end

  assign line_add    = add_q;
  assign line_drop   = drop_q;
  assign frame_reset = rst_q;

endmodule

// File: rtl/frame_slip_lock.sv
module frame_slip_lock
  import fsl_pkg::*;
#(
  parameter int LINES_PER_FRAME = 625,
  parameter int LOCK_FRAMES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lock_mode,
  input  logic       vlock_en,
  input  logic       line_tick,
  input  logic       int_frame,
  input  logic       ext_vert,
  output logic       line_add,
  output logic       line_drop,
  output logic       frame_reset,
  output logic       in_lock
);

  localparam int HALF_LINES = LINES_PER_FRAME / 2;
  localparam int CNT_W      = $clog2(HALF_LINES + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             active;
  meas_evt_t        evt;
  logic [CNT_W-1:0] err;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  assign active = (lock_mode != MODE_SUBCARRIER);

  fsl_phase_meter #(
    .HALF_LINES (HALF_LINES),
    .CNT_W      (CNT_W)
  ) u_meter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .active    (active),
    .line_tick (line_tick),
    .int_frame (int_frame),
    .ext_vert  (ext_vert),
    .evt       (evt),
    .err       (err)
  );

  fsl_lock_qual #(
    .LOCK_FRAMES (LOCK_FRAMES),
    .ERR_W       (CNT_W),
    .TOL_LINES   (1)
  ) u_qual (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .active       (active),
    .meas_done    (evt.done),
    .meas_expired (evt.expired),
    .err          (err),
    .in_lock      (in_lock)
  );

  fsl_corr_req #(
    .ERR_W (CNT_W)
  ) u_req (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .lock_mode   (lock_mode),
    .vlock_en    (vlock_en),
    .ext_vert    (ext_vert),
    .evt         (evt),
    .err         (err),
    .line_add    (line_add),
    .line_drop   (line_drop),
    .frame_reset (frame_reset)
  );

endmodule

// File: rtl/frame_slip_lock_chk.sv
module frame_slip_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] lock_mode,
  input logic       vlock_en,
  input logic       int_frame,
  input logic       ext_vert,
  input logic       line_add,
  input logic       line_drop,
  input logic       frame_reset,
  input logic       in_lock
);

  // R1
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mode == 2'b00) |=> !(line_add || line_drop || frame_reset || in_lock));

  // R2
  drop_after_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_drop |-> $past(int_frame));

  // R3
  add_after_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_add |-> $past(ext_vert));

  // R5
  no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_add && line_drop));

  // R5
  add_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_add |=> !line_add);

  // R5
  drop_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_drop |=> !line_drop);

  // R6
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vlock_en |=> !(line_add || line_drop || frame_reset));

  // R7
  fast_reset_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_reset |-> ($past(ext_vert) && ($past(lock_mode) == 2'b11)));

  // R7
  fast_no_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_mode == 2'b11) |=> !(line_add || line_drop));

  // R9
  lock_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_lock) |-> $past(int_frame || ext_vert));

endmodule

bind frame_slip_lock frame_slip_lock_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lock_mode   (lock_mode),
  .vlock_en    (vlock_en),
  .int_frame   (int_frame),
  .ext_vert    (ext_vert),
  .line_add    (line_add),
  .line_drop   (line_drop),
  .frame_reset (frame_reset),
  .in_lock     (in_lock)
);

// File: tb/frame_slip_lock_bench.sv
module frame_slip_lock_bench;

  localparam int LINES    = 16;
  localparam int HALF     = LINES / 2;
  localparam int LOCKN    = 2;
  localparam int TICK_DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] lock_mode;
  logic       vlock_en;
  logic       line_tick;
  logic       int_frame;
  logic       ext_vert;
  logic       line_add, line_drop, frame_reset, in_lock;

  int n_chk = 0;
  int n_fail = 0;
  int phase = 0;
  int add_seen = 0, drop_seen = 0, rst_seen = 0;
  bit cmp_on = 1'b0;

  // behavioural reference state
  int m_st, m_cnt, m_good;
  bit m_lock, m_add, m_drop, m_rst;

  always #10 clk = ~clk;

  frame_slip_lock #(
    .LINES_PER_FRAME (LINES),
    .LOCK_FRAMES     (LOCKN)
  ) u_frame_slip_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .lock_mode   (lock_mode),
    .vlock_en    (vlock_en),
    .line_tick   (line_tick),
    .int_frame   (int_frame),
    .ext_vert    (ext_vert),
    .line_add    (line_add),
    .line_drop   (line_drop),
    .frame_reset (frame_reset),
    .in_lock     (in_lock)
  );

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic grade(input int sep);
    if (sep <= 1) begin
      if (m_good < LOCKN) m_good++;
      m_lock = (m_good >= LOCKN);
    end else begin
      m_good = 0;
      m_lock = 1'b0;
    end
  endtask

  // Reference model: strobe separation measured in line ticks.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_good = 0;
      m_lock = 0; m_add = 0; m_drop = 0; m_rst = 0;
    end else begin
      bit slow;
      slow   = (lock_mode == 2'b01) || (lock_mode == 2'b10);
      m_add  = 0;
      m_drop = 0;
      m_rst  = vlock_en && (lock_mode == 2'b11) && ext_vert;
      if (lock_mode == 2'b00) begin
        m_st = 0; m_cnt = 0; m_good = 0; m_lock = 0;
      end else if (m_st == 0) begin
        m_cnt = 0;
        if (int_frame && ext_vert) grade(0);
        else if (int_frame) m_st = 1;
        else if (ext_vert) m_st = 2;
      end else begin
        bit closer;
        closer = (m_st == 1) ? ext_vert : int_frame;
        if (closer) begin
          grade(m_cnt);
          if (vlock_en && slow && m_cnt >= 1) begin
            if (m_st == 1) m_add = 1;
            else m_drop = 1;
          end
          m_st = 0;
        end else if (line_tick) begin
          if (m_cnt == HALF - 1) begin
            m_good = 0; m_lock = 0; m_st = 0;
          end else begin
            m_cnt++;
          end
        end
      end
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 line_add", int'(line_add), int'(m_add));
      chk("R2 line_drop", int'(line_drop), int'(m_drop));
      chk("R7 frame_reset", int'(frame_reset), int'(m_rst));
      chk("R9 in_lock", int'(in_lock), int'(m_lock));
      chk("R5 add and drop together", int'(line_add && line_drop), 0);
      add_seen  += int'(line_add);
      drop_seen += int'(line_drop);
      rst_seen  += int'(frame_reset);
    end
  end

  task automatic cycle(input logic i, input logic e);
    @(negedge clk);
    int_frame = i;
    ext_vert  = e;
    line_tick = (phase == TICK_DIV - 1);
    phase     = (phase + 1) % TICK_DIV;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cycle(1'b0, 1'b0);
  endtask

  task automatic clr();
    add_seen = 0; drop_seen = 0; rst_seen = 0;
  endtask

  // gap in clock cycles between first and second strobe
  task automatic pair(input bit int_first, input int gap);
    if (gap == 0) begin
      cycle(1'b1, 1'b1);
    end else begin
      cycle(int_first, !int_first);
      idle(gap - 1);
      cycle(!int_first, int_first);
    end
    idle(4);
  endtask

  task automatic park();
    lock_mode = 2'b00;
    idle(3);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lock_mode = 2'b00; vlock_en = 1'b0;
    line_tick = 1'b0; int_frame = 1'b0; ext_vert = 1'b0;
    idle(3);
    // R10 reset state
    chk("R10 outputs in reset", int'({line_add, line_drop, frame_reset, in_lock}), 0);
    rst_n = 1'b1;
    idle(1);
    chk("R10 outputs after release", int'({line_add, line_drop, frame_reset, in_lock}), 0);
    idle(4);
    cmp_on = 1'b1;

    // R2 external leads by 3 lines
    vlock_en = 1'b1; lock_mode = 2'b10; clr();
    pair(1'b0, 12);
    chk("R2 drop count", drop_seen, 1);
    chk("R5 no add with drop", add_seen, 0);
    park();

    // R3 external lags by 3 lines
    lock_mode = 2'b01; clr();
    pair(1'b1, 12);
    chk("R3 add count", add_seen, 1);
    chk("R5 no drop with add", drop_seen, 0);
    park();

    // R4 same cycle
    lock_mode = 2'b10; clr();
    pair(1'b1, 0);
    chk("R4 no request", add_seen + drop_seen, 0);
    park();

    // R1 subcarrier mode ignores strobes
    lock_mode = 2'b00; clr();
    pair(1'b0, 12);
    pair(1'b1, 0);
    pair(1'b1, 0);
    chk("R1 no request", add_seen + drop_seen + rst_seen, 0);
    chk("R1 in_lock low", int'(in_lock), 0);

    // R6 enable low
    vlock_en = 1'b0; lock_mode = 2'b01; clr();
    pair(1'b1, 12);
    lock_mode = 2'b11;
    pair(1'b0, 12);
    chk("R6 no request", add_seen + drop_seen + rst_seen, 0);
    park();

    // R7 fast mode
    vlock_en = 1'b1; lock_mode = 2'b11; clr();
    pair(1'b0, 12);
    chk("R7 reset count", rst_seen, 1);
    chk("R7 no slip", add_seen + drop_seen, 0);
    park();

    // R9 lock qualification
    lock_mode = 2'b10; clr();
    pair(1'b1, 0);
    chk("R9 one good frame", int'(in_lock), 0);
    pair(1'b0, 2);
    chk("R9 two good frames", int'(in_lock), 1);
    pair(1'b1, 16);
    chk("R9 large error drops lock", int'(in_lock), 0);
    pair(1'b1, 0);
    pair(1'b1, 0);
    chk("R9 relock", int'(in_lock), 1);

    // R8 window expiry
    clr();
    cycle(1'b1, 1'b0);
    idle(HALF * TICK_DIV + 8);
    chk("R8 expiry clears lock", int'(in_lock), 0);
    chk("R8 no request", add_seen + drop_seen, 0);
    park();

    cmp_on = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule